// File: doc/BRIEF.md
# Memory Cycle Timing Controller

This block sequences one processor memory or I/O access at a time. A falling edge on the active-low start strobe opens a cycle: the controller captures the bus address, the write/read flag and a per-access "slow target" flag. It then drives the address onto the bus under an output-enable, and it turns on the bidirectional data-bus buffers in the direction that matches the transfer. A rising edge on a separate fetch strobe during the cycle marks the held address as an instruction address.

A rising edge on the processor's synchronous completion signal normally ends the access. For slow targets, the controller instead holds the cycle open until an asynchronous ready input arrives through a two-flop synchronizer. A 16-clock wait watchdog forces the end of the cycle if ready never comes and raises a sticky timeout flag. The cycle closes with a one-clock extended completion strobe. Its rising edge is where read data is taken by the processor or write data is taken by RAM.

The controller has four states:
- IDLE waits for the start strobe.
- LATCHED holds the cycle until the completion edge.
- WAIT_RDY waits for ready or for the watchdog.
- DONE drives the completion strobe.

The transitions are:
- IDLE→LATCHED on an accepted start.
- LATCHED→DONE on a completion edge for a normal target.
- LATCHED→WAIT_RDY on a completion edge for a slow target.
- WAIT_RDY→DONE on synchronized ready or on watchdog expiry.
- DONE→IDLE unconditionally after one clock.

Top module: `mem_cycle_ctrl`

## Requirements
- R1: After reset, `xdone`, `buf_en`, `addr_drv`, `is_fetch` and `timeout_flag` are all 0.
- R2: When `start_n` is sampled low on a clock edge, having been high on the previous edge, while the controller is idle, `addr_in` is captured. `addr_out` then holds that value through the whole cycle, whatever `addr_in` does.
- R3: `addr_drv` (the address output-enable) equals `addr_oe` while a cycle is in progress and is 0 when idle.
- R4: For a normal target (`slow_in`=0 at start), `xdone` is high starting with the clock edge that first samples `sync_done` high. It stays high for exactly one clock, and the controller is idle on the next edge.
- R5: For a slow target (`slow_in`=1), the completion edge does not end the cycle. `xdone` rises on the second clock edge after the first edge that samples `async_rdy` high. It never rises sooner than that, and never sooner than two edges after the completion edge.
- R6: If synchronized ready has not arrived after 16 clocks in the ready wait, `xdone` is forced high. This happens on the 16th edge after the completion edge, and `timeout_flag` is set at the same time. `timeout_flag` stays 1 until reset.
- R7: `is_fetch` is 1 if `fetch_strobe` rose on the accepting edge or at any later edge of the cycle. An accepted start with no fetch rise clears it to 0.
- R8: `buf_en` is 1 from the accepting edge through the `xdone` clock and 0 when idle. `buf_dir` is 1 (processor→memory) for a write (`wr_in`=1) and 0 (memory→processor) for a read.
- R9: A fall on `start_n` while a cycle is in progress is ignored. The held address, the direction and the completion timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low start-of-cycle strobe; falling edge opens a cycle |
| fetch_strobe | input | 1 | Rising edge marks the cycle as an instruction fetch |
| addr_in | input | AW | Address from the processor bus |
| addr_oe | input | 1 | Request to drive the held address onto the bus |
| wr_in | input | 1 | 1 = write, 0 = read, sampled at start |
| slow_in | input | 1 | 1 = target needs ready handshake, sampled at start |
| sync_done | input | 1 | Synchronous completion; rising edge ends the access phase |
| async_rdy | input | 1 | Asynchronous ready from slow targets |
| addr_out | output | AW | Held address |
| addr_drv | output | 1 | Tri-state enable for the address outputs |
| is_fetch | output | 1 | Current cycle is an instruction fetch |
| xdone | output | 1 | Extended completion strobe, one clock wide |
| buf_en | output | 1 | Data-bus buffer enable |
| buf_dir | output | 1 | Buffer direction: 1 processor→memory, 0 memory→processor |
| timeout_flag | output | 1 | Sticky ready-wait timeout |

## Verification
The hardest states to reach from the ports are the ones where the slow-target wait overlaps other activity. One is the wait that ends on the watchdog rather than on ready. Another is a fresh start strobe falling in the middle of a wait.

The stimulus reaches them in three ways:
- It raises the completion edge on a slow cycle and withholds ready entirely, so the wait must run for the full 16 clocks.
- On another slow cycle it delays ready by several clocks, and it pulses `start_n` with a different address inside that window.
- For each cycle, the scoreboard predicts the exact clock of `xdone` from the ready delay, counting both synchronizer stages. It then compares the held address, the direction, the fetch mark and the timeout flag at that clock.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LATCHED  = 2'd1,
        ST_WAIT_RDY = 2'd2,
        ST_DONE     = 2'd3
    } mcc_state_t;
endpackage

// File: rtl/mcc_edge.sv
// Registers a level and reports its rising and falling edges.
module mcc_edge #(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic d_q;

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= IDLE_LEVEL;
        else        d_q <= d;
    end

    assign rise = d & ~d_q;
    assign fall = ~d & d_q;
endmodule

// File: rtl/mcc_sync.sv
// Multi-stage synchronizer for an asynchronous level.
module mcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mcc_wait_timer.sv
// Counts clocks while run is high; expired on the last permitted clock.
module mcc_wait_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/mcc_addr_latch.sv
// Address holding register loaded at cycle start.
module mcc_addr_latch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/mem_cycle_ctrl.sv
module mem_cycle_ctrl
    import mcc_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SYNC_LEN = 2,
    parameter int WAIT_MAX = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_n,
    input  logic          fetch_strobe,
    input  logic [AW-1:0] addr_in,
    input  logic          addr_oe,
    input  logic          wr_in,
    input  logic          slow_in,
    input  logic          sync_done,
    input  logic          async_rdy,
    output logic [AW-1:0] addr_out,
    output logic          addr_drv,
    output logic          is_fetch,
    output logic          xdone,
    output logic          buf_en,
    output logic          buf_dir,
    output logic          timeout_flag
);
    mcc_state_t state, state_nx;

    logic start_fall, start_rise_unused;
    logic fetch_rise, fetch_fall_unused;
    logic done_rise, done_fall_unused;
    logic rdy_s, wait_expired;
    logic wr_q, slow_q;
    logic accept;

    mcc_edge #(.IDLE_LEVEL(1'b1)) u_start_edge (
        .clk(clk), .rst_n(rst_n), .d(start_n),
        .rise(start_rise_unused), .fall(start_fall)
    );

    mcc_edge #(.IDLE_LEVEL(1'b0)) u_fetch_edge (
        .clk(clk), .rst_n(rst_n), .d(fetch_strobe),
        .rise(fetch_rise), .fall(fetch_fall_unused)
    );

    mcc_edge #(.IDLE_LEVEL(1'b0)) u_done_edge (
        .clk(clk), .rst_n(rst_n), .d(sync_done),
        .rise(done_rise), .fall(done_fall_unused)
    );

    mcc_sync #(.STAGES(SYNC_LEN)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .d(async_rdy), .q(rdy_s)
    );

    mcc_wait_timer #(.LIMIT(WAIT_MAX)) u_wait_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT_RDY),
        .expired(wait_expired)
    );

    assign accept = (state == ST_IDLE) && start_fall;

    mcc_addr_latch #(.AW(AW)) u_addr_latch (
        .clk(clk), .rst_n(rst_n), .load(accept), .d(addr_in), .q(addr_out)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start_fall) state_nx = ST_LATCHED;
            ST_LATCHED:  if (done_rise)  state_nx = slow_q ? ST_WAIT_RDY : ST_DONE;
            ST_WAIT_RDY: if (rdy_s || wait_expired) state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Registered per-cycle attributes and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q         <= 1'b0;
            slow_q       <= 1'b0;
            is_fetch     <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            if (accept) begin
                wr_q     <= wr_in;
                slow_q   <= slow_in;
                is_fetch <= fetch_rise;
            end else if (state != ST_IDLE && fetch_rise) begin
                is_fetch <= 1'b1;
            end
            if (state == ST_WAIT_RDY && !rdy_s && wait_expired)
                timeout_flag <= 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        xdone    = (state == ST_DONE);
        buf_en   = (state != ST_IDLE);
        buf_dir  = wr_q;
        addr_drv = addr_oe && (state != ST_IDLE);
    end
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    state,
    input logic          done_rise,
    input logic          slow_q,
    input logic          rdy_s,
    input logic          wait_expired,
    input logic [AW-1:0] addr_out,
    input logic          addr_drv,
    input logic          xdone,
    input logic          buf_en,
    input logic          buf_dir,
    input logic          timeout_flag
);
    localparam logic [1:0] S_LATCHED = 2'd1;
    localparam logic [1:0] S_WAIT    = 2'd2;

    a_r4_xdone_single: assert property (@(posedge clk) disable iff (!rst_n)
        xdone |=> !xdone);

    a_r4_fast_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LATCHED && done_rise && !slow_q) |=> xdone);

    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        xdone |=> !buf_en);

    a_r6_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag);

    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && $past(buf_en)) |-> $stable(addr_out));

    a_r8_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && $past(buf_en)) |-> $stable(buf_dir));

    a_r3_drive_only_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        addr_drv |-> buf_en);

    a_r5_wait_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (xdone && $past(state) == S_WAIT) |-> ($past(rdy_s) || $past(wait_expired)));
endmodule

bind mem_cycle_ctrl mcc_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .done_rise(done_rise),
    .slow_q(slow_q), .rdy_s(rdy_s), .wait_expired(wait_expired),
    .addr_out(addr_out), .addr_drv(addr_drv), .xdone(xdone),
    .buf_en(buf_en), .buf_dir(buf_dir), .timeout_flag(timeout_flag)
);

// File: tb/sim_mem_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_mem_cycle_ctrl;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_n = 1'b1, fetch_strobe = 1'b0, addr_oe = 1'b1;
    logic wr_in = 1'b0, slow_in = 1'b0, sync_done = 1'b0, async_rdy = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic addr_drv, is_fetch, xdone, buf_en, buf_dir, timeout_flag;

    always #4 clk = ~clk;

    mem_cycle_ctrl #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .fetch_strobe(fetch_strobe),
        .addr_in(addr_in), .addr_oe(addr_oe), .wr_in(wr_in), .slow_in(slow_in),
        .sync_done(sync_done), .async_rdy(async_rdy), .addr_out(addr_out),
        .addr_drv(addr_drv), .is_fetch(is_fetch), .xdone(xdone), .buf_en(buf_en),
        .buf_dir(buf_dir), .timeout_flag(timeout_flag)
    );

    typedef struct {
        int            cyc;
        logic [AW-1:0] addr;
        logic          dir;
        logic          fetch;
        logic          tmo;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    logic tmo_seen = 1'b0;
    logic finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops the expectation when the completion strobe is seen
    always @(negedge clk) begin
        if (rst_n && xdone) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected xdone", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R4/R5/R6 xdone cycle", 32'(cyc), 32'(e.cyc));
                chk("R2/R9 held address", 32'(addr_out), 32'(e.addr));
                chk("R8 direction", 32'(buf_dir), 32'(e.dir));
                chk("R8 enable at xdone", 32'(buf_en), 32'd1);
                chk("R7 fetch mark", 32'(is_fetch), 32'(e.fetch));
                chk("R6 timeout flag", 32'(timeout_flag), 32'(e.tmo));
            end
        end
    end

    // Driver: one access; rdel < 0 means ready never comes
    task automatic run_cycle(input logic [AW-1:0] a, input logic w, input logic s,
                             input logic f, input int rdel, input logic glitch);
        exp_t e;
        int   c;
        @(negedge clk);
        start_n = 1'b0; addr_in = a; wr_in = w; slow_in = s; fetch_strobe = f;
        @(negedge clk);
        start_n = 1'b1; fetch_strobe = 1'b0; addr_in = ~a;
        wr_in = ~w; slow_in = ~s;
        chk("R8 enable in cycle", 32'(buf_en), 32'd1);
        chk("R8 direction in cycle", 32'(buf_dir), 32'(w));
        chk("R3 address driven", 32'(addr_drv), 32'd1);
        chk("R4 no early xdone", 32'(xdone), 32'd0);
        addr_oe = 1'b0;
        #1;
        chk("R3 address released", 32'(addr_drv), 32'd0);
        @(negedge clk);
        addr_oe = 1'b1;
        sync_done = 1'b1;
        c = cyc;
        if (!s)            e.cyc = c + 1;
        else if (rdel < 0) e.cyc = c + 17;
        else               e.cyc = c + rdel + 3;
        if (s && rdel < 0) tmo_seen = 1'b1;
        e.addr = a; e.dir = w; e.fetch = f; e.tmo = tmo_seen;
        exp_q.push_back(e);
        if (s && rdel == 0) async_rdy = 1'b1;
        if (s && rdel > 0) begin
            for (int i = 1; i <= rdel; i++) begin
                @(negedge clk);
                if (glitch && i == 1) begin start_n = 1'b0; addr_in = a ^ 16'h5A5A; end
                if (glitch && i == 2) start_n = 1'b1;
                if (i == 2) chk("R5 still waiting", 32'(xdone), 32'd0);
            end
            async_rdy = 1'b1;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        chk("R4 single-clock xdone", 32'(xdone), 32'd0);
        chk("R8 idle enable off", 32'(buf_en), 32'd0);
        chk("R3 idle no drive", 32'(addr_drv), 32'd0);
        sync_done = 1'b0; async_rdy = 1'b0; start_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 xdone reset", 32'(xdone), 32'd0);
        chk("R1 buf_en reset", 32'(buf_en), 32'd0);
        chk("R1 addr_drv reset", 32'(addr_drv), 32'd0);
        chk("R1 is_fetch reset", 32'(is_fetch), 32'd0);
        chk("R1 timeout reset", 32'(timeout_flag), 32'd0);

        run_cycle(16'h1234, 1'b0, 1'b0, 1'b0, 0, 1'b0);   // R4 fast read
        run_cycle(16'hABCD, 1'b1, 1'b0, 1'b1, 0, 1'b0);   // R4 fast write, R7 fetch
        run_cycle(16'h00F1, 1'b0, 1'b1, 1'b1, 0, 1'b0);   // R5 ready at once
        run_cycle(16'h7E11, 1'b1, 1'b1, 1'b0, 5, 1'b1);   // R5 delayed ready, R9 restart ignored
        run_cycle(16'hC003, 1'b0, 1'b1, 1'b0, -1, 1'b0);  // R6 watchdog
        run_cycle(16'h0F0F, 1'b1, 1'b0, 1'b0, 0, 1'b0);   // R6 sticky, R7 cleared

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule